// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block is the receive front end of an I2C target. It watches the SCL and SDA wires after bringing both into the system clock domain. It detects the bus conditions that open and close a transfer, and shifts the first byte after each opening condition into a data register. It then decides whether the controller on the bus is calling this node.

The upper seven bits of that first byte are compared with a programmable own address. When they match, the block raises an addressed flag. It pulls SDA low for the acknowledge clock and records the direction bit, so that the rest of the target knows whether it must send or receive. When the bits do not match, the block stays silent until the next opening condition. A bus-busy flag follows the opening and closing conditions, whatever the address result.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset, sda_pull, addressed, xmit_dir and bus_busy are 0 and rx_byte is 8'h00.
- R2: A START (synchronized SDA going 1 to 0 while SCL is 1) sets bus_busy to 1 and clears xmit_dir and addressed.
- R3: After a START, the next eight SCL rising edges shift SDA into rx_byte, first bit into bit 7, so rx_byte holds the whole byte after the eighth rise.
- R4: When rx_byte[7:1] equals own_addr after the eighth rise, addressed becomes 1.
- R5: On a match, xmit_dir takes rx_byte[0] (1 means the controller reads and this node must send).
- R6: On a match, sda_pull is 1 from the SCL falling edge after the eighth bit until the SCL falling edge that ends the ninth clock, and is 0 afterwards.
- R7: On a mismatch, sda_pull stays 0 through the ninth clock and addressed and xmit_dir stay 0.
- R8: A STOP (synchronized SDA going 0 to 1 while SCL is 1) clears bus_busy, addressed, xmit_dir and sda_pull.
- R9: A repeated START while bus_busy is 1 clears addressed and xmit_dir, keeps bus_busy at 1 and restarts address reception, so a fresh byte is judged on its own.
- R10: A STOP that arrives before the eighth address bit ends reception: no acknowledge is driven and addressed stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| scl_in | input | 1 | SCL wire level, asynchronous |
| sda_in | input | 1 | SDA wire level, asynchronous |
| own_addr | input | 7 | Programmed 7-bit own address |
| sda_pull | output | 1 | Enable for the open-drain pull-down on SDA |
| rx_byte | output | 8 | Received address byte |
| addressed | output | 1 | Node has been addressed as target |
| xmit_dir | output | 1 | Direction bit latched on a match, 1 = node transmits |
| bus_busy | output | 1 | A transfer is open on the bus |

## Verification
Two actions can land in the same clock. The first is a repeated START arriving while the addressed flag from an earlier match is still held. Here the old flag must be cleared and a new byte started in one step, so the bench sends a matching read address and then a repeated START. It checks that addressed and xmit_dir drop while bus_busy stays high, and that a mismatching byte sent next draws no acknowledge. The second is a STOP arriving part-way through the address byte. Here the busy flag must fall and the unfinished reception must be dropped together, so the bench stops the bus after four bits and checks that no pull-down or addressed flag follows.

// File: rtl/i2c_am_pkg.sv
// Package: shared types for the I2C address matcher.
// Assumes: a byte is one address field plus one direction bit.
package i2c_am_pkg;

    // Receive sequencer states.
    typedef enum logic [2:0] {
        RX_IDLE     = 3'd0,  // no transfer open
        RX_ADDR     = 3'd1,  // shifting address bits
        RX_ACK_WAIT = 3'd2,  // byte complete, waiting for SCL to fall
        RX_ACK      = 3'd3,  // ninth clock, pull-down held on match
        RX_HOLD     = 3'd4   // address phase over, wait for START/STOP
    } rx_state_t;

    // Single-cycle bus events derived from the synchronized lines.
    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
    } bus_evt_t;

endpackage

// File: rtl/i2c_am_sync.sv
// Module: multi-stage synchronizer for a group of asynchronous lines.
// Assumes: each line is a level that is slow relative to clk; the reset
// value is the idle level of the lines, so no edge appears at reset release.
module i2c_am_sync #(
    parameter int unsigned STAGES    = 2,
    parameter int unsigned WIDTH     = 2,
    parameter logic        RESET_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    localparam int unsigned LAST = STAGES - 1;

    for (genvar g = 0; g < WIDTH; g++) begin : g_line
        logic [STAGES-1:0] chain;

        // Shift one line through its flop chain.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain <= {STAGES{RESET_VAL}};
            end else if (STAGES > 1) begin
                chain <= {chain[STAGES-2:0], async_in[g]};
            end else begin
                chain <= async_in[g];
            end
        end

        assign sync_out[g] = chain[LAST];
    end

endmodule

// File: rtl/i2c_am_cond.sv
// Module: bus condition detector.
// Detects SCL edges and START/STOP conditions from synchronized lines
// and tracks whether the bus is busy.
// Assumes: both lines were synchronized by the same number of stages,
// so a true START or STOP shows SDA moving while SCL is steady high.
module i2c_am_cond
    import i2c_am_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_s,
    input  logic     sda_s,
    output bus_evt_t evt,
    output logic     bus_busy
);

    logic scl_q;
    logic sda_q;
    logic scl_steady_high;

    // Hold the previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_steady_high = scl_s & scl_q;

    // Decode one-cycle events from the sampled pairs.
    always_comb begin
        evt.start    = scl_steady_high & sda_q & ~sda_s;
        evt.stop     = scl_steady_high & ~sda_q & sda_s;
        evt.scl_rise = scl_s & ~scl_q;
        evt.scl_fall = ~scl_s & scl_q;
    end

    // Track bus ownership: START opens, STOP closes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_busy <= 1'b0;
        end else if (evt.start) begin
            bus_busy <= 1'b1;
        end else if (evt.stop) begin
            bus_busy <= 1'b0;
        end
    end

endmodule

// File: rtl/i2c_am_rx.sv
// Module: address receiver.
// Shifts the first byte after each START, compares its upper bits with
// the own address, drives the acknowledge and latches the direction bit.
// Assumes: events come from i2c_am_cond; START and STOP never share a
// cycle with an SCL edge because both need SCL high in two samples.
module i2c_am_rx
    import i2c_am_pkg::*;
#(
    parameter int unsigned ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_evt_t          evt,
    input  logic              sda_s,
    input  logic [ADDR_W-1:0] own_addr,
    output logic              sda_pull,
    output logic [ADDR_W:0]   rx_byte,
    output logic              addressed,
    output logic              xmit_dir
);

    localparam int unsigned BYTE_W = ADDR_W + 1;
    localparam int unsigned CNT_W  = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    rx_state_t        state;
    rx_state_t        state_nx;
    logic [CNT_W-1:0] bit_cnt;
    logic             byte_done;
    logic             addr_hit;

    // The eighth rise completes the byte; its upper bits are already held.
    assign byte_done = (state == RX_ADDR) && evt.scl_rise && (bit_cnt == LAST_BIT);
    assign addr_hit  = (rx_byte[ADDR_W-1:0] == own_addr);

    // Choose the next sequencer state.
    always_comb begin
        state_nx = state;
        if (evt.start) begin
            state_nx = RX_ADDR;
        end else if (evt.stop) begin
            state_nx = RX_IDLE;
        end else begin
            unique case (state)
                RX_ADDR:     if (byte_done)    state_nx = RX_ACK_WAIT;
                RX_ACK_WAIT: if (evt.scl_fall) state_nx = RX_ACK;
                RX_ACK:      if (evt.scl_fall) state_nx = RX_HOLD;
                default:     state_nx = state;
            endcase
        end
    end

    // Register the sequencer state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RX_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Count address bits and shift SDA in, most significant bit first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            rx_byte <= '0;
        end else if (evt.start) begin
            bit_cnt <= '0;
            rx_byte <= '0;
        end else if ((state == RX_ADDR) && evt.scl_rise) begin
            rx_byte <= {rx_byte[ADDR_W-1:0], sda_s};
            bit_cnt <= byte_done ? '0 : bit_cnt + 1'b1;
        end
    end

    // Set the match flags when the byte completes; clear on START/STOP.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addressed <= 1'b0;
            xmit_dir  <= 1'b0;
        end else if (evt.start || evt.stop) begin
            addressed <= 1'b0;
            xmit_dir  <= 1'b0;
        end else if (byte_done && addr_hit) begin
            addressed <= 1'b1;
            xmit_dir  <= sda_s;
        end
    end

    // Drive the acknowledge across the ninth SCL clock on a match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sda_pull <= 1'b0;
        end else if (evt.start || evt.stop) begin
            sda_pull <= 1'b0;
        end else if ((state == RX_ACK_WAIT) && evt.scl_fall) begin
            sda_pull <= addressed;
        end else if ((state == RX_ACK) && evt.scl_fall) begin
            sda_pull <= 1'b0;
        end
    end

endmodule

// File: rtl/i2c_addr_match.sv
// Module: I2C target address matcher, top level.
// Synchronizes SCL/SDA, detects bus conditions and judges the address
// byte against own_addr.
// Assumes: sda_pull drives an external open-drain pad; sda_in reads the
// wire, so the block sees its own acknowledge on the line.
module i2c_addr_match
    import i2c_am_pkg::*;
#(
    parameter int unsigned ADDR_W      = 7,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic [ADDR_W-1:0] own_addr,
    output logic              sda_pull,
    output logic [ADDR_W:0]   rx_byte,
    output logic              addressed,
    output logic              xmit_dir,
    output logic              bus_busy
);

    localparam int unsigned LINES = 2;

    logic [LINES-1:0] lines_sync;
    logic             scl_s;
    logic             sda_s;
    bus_evt_t         evt;
    logic             start_det;
    logic             stop_det;

    i2c_am_sync #(
        .STAGES    (SYNC_STAGES),
        .WIDTH     (LINES),
        .RESET_VAL (1'b1)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({sda_in, scl_in}),
        .sync_out (lines_sync)
    );

    assign scl_s = lines_sync[0];
    assign sda_s = lines_sync[1];

    i2c_am_cond u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .evt      (evt),
        .bus_busy (bus_busy)
    );

    assign start_det = evt.start;
    assign stop_det  = evt.stop;

    i2c_am_rx #(
        .ADDR_W (ADDR_W)
    ) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (evt),
        .sda_s     (sda_s),
        .own_addr  (own_addr),
        .sda_pull  (sda_pull),
        .rx_byte   (rx_byte),
        .addressed (addressed),
        .xmit_dir  (xmit_dir)
    );

endmodule

// File: rtl/i2c_addr_match_chk.sv
// Module: property checker for i2c_addr_match, attached by bind.
// Assumes: start_det/stop_det are the one-cycle bus events inside the top.
module i2c_addr_match_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_s,
    input logic start_det,
    input logic stop_det,
    input logic sda_pull,
    input logic addressed,
    input logic xmit_dir,
    input logic bus_busy
);

    AST_START_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (bus_busy && !xmit_dir && !addressed)); // R2

    AST_RESTART_CLEARS_PULL: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_pull); // R9

    AST_STOP_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!bus_busy && !addressed && !sda_pull && !xmit_dir)); // R8

    AST_ADDR_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        addressed |-> bus_busy); // R4

    AST_DIR_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        xmit_dir |-> addressed); // R5

    AST_PULL_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        sda_pull |-> addressed); // R7

    AST_PULL_RISES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> !scl_s); // R6

endmodule

bind i2c_addr_match i2c_addr_match_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_pull  (sda_pull),
    .addressed (addressed),
    .xmit_dir  (xmit_dir),
    .bus_busy  (bus_busy)
);

// File: tb/i2c_addr_match_bench.sv
// Bench: table-driven address cases, then directed reset and corner tests.
module i2c_addr_match_bench;

    localparam int Q = 10;   // clocks per quarter of an SCL bit
    localparam int NV = 7;
    localparam int WATCHDOG = 150000;

    // Fields: [16:10] own address, [9:2] byte sent, [1] expect match, [0] expect dir
    localparam logic [16:0] VEC [NV] = '{
        {7'h50, 8'hA0, 1'b1, 1'b0},
        {7'h50, 8'hA1, 1'b1, 1'b1},
        {7'h50, 8'hA2, 1'b0, 1'b0},
        {7'h7F, 8'hFF, 1'b1, 1'b1},
        {7'h00, 8'h00, 1'b1, 1'b0},
        {7'h2A, 8'h55, 1'b1, 1'b1},
        {7'h2A, 8'hD5, 1'b0, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [6:0] own_addr = 7'h00;
    logic       sda_pull;
    logic [7:0] rx_byte;
    logic       addressed;
    logic       xmit_dir;
    logic       bus_busy;
    logic       sda_wire;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    // Open-drain wire: either side can pull SDA low.
    assign sda_wire = sda_m & ~sda_pull;

    i2c_addr_match u_i2c_addr_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_m),
        .sda_in    (sda_wire),
        .own_addr  (own_addr),
        .sda_pull  (sda_pull),
        .rx_byte   (rx_byte),
        .addressed (addressed),
        .xmit_dir  (xmit_dir),
        .bus_busy  (bus_busy)
    );

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG && !done) begin
            done = 1'b1;
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL watchdog actual %0d cycles expected < %0d", cycles, WATCHDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; idle(Q);
        scl_m = 1'b1; idle(Q);
        sda_m = 1'b0; idle(Q);
        scl_m = 1'b0; idle(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; idle(Q);
        scl_m = 1'b1; idle(Q);
        sda_m = 1'b1; idle(Q);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;    idle(Q);
        scl_m = 1'b1; idle(2 * Q);
        scl_m = 1'b0; idle(Q);
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
    endtask

    // Ninth clock: controller releases SDA, target may pull it low.
    task automatic ack_clock(input logic exp_pull, input string tag);
        sda_m = 1'b1; idle(Q);
        chk({tag, " R6 pull before 9th rise"}, {7'd0, sda_pull}, {7'd0, exp_pull});
        scl_m = 1'b1; idle(Q);
        chk({tag, " R6/R7 pull in 9th high"}, {7'd0, sda_pull}, {7'd0, exp_pull});
        chk({tag, " R6 wire level in 9th high"}, {7'd0, sda_wire}, {7'd0, ~exp_pull});
        idle(Q);
        scl_m = 1'b0; idle(Q);
        chk({tag, " R6 pull released after 9th fall"}, {7'd0, sda_pull}, 8'd0);
    endtask

    initial begin
        // R1: reset state
        idle(4);
        chk("R1 sda_pull", {7'd0, sda_pull}, 8'd0);
        chk("R1 addressed", {7'd0, addressed}, 8'd0);
        chk("R1 xmit_dir", {7'd0, xmit_dir}, 8'd0);
        chk("R1 bus_busy", {7'd0, bus_busy}, 8'd0);
        chk("R1 rx_byte", rx_byte, 8'h00);
        rst_n = 1'b1;
        idle(4);
        chk("R1 idle after release", {7'd0, bus_busy}, 8'd0);

        // Table walk: R2..R8 per vector
        for (int v = 0; v < NV; v++) begin
            logic [7:0] b;
            logic       hit;
            logic       dir;
            own_addr = VEC[v][16:10];
            b   = VEC[v][9:2];
            hit = VEC[v][1];
            dir = VEC[v][0];
            bus_start();
            chk($sformatf("R2 v%0d busy after start", v), {7'd0, bus_busy}, 8'd1);
            chk($sformatf("R2 v%0d dir after start", v), {7'd0, xmit_dir}, 8'd0);
            send_byte(b);
            chk($sformatf("R3 v%0d rx_byte", v), rx_byte, b);
            chk($sformatf("R4/R7 v%0d addressed", v), {7'd0, addressed}, {7'd0, hit});
            chk($sformatf("R5/R7 v%0d xmit_dir", v), {7'd0, xmit_dir}, {7'd0, dir});
            ack_clock(hit, $sformatf("v%0d", v));
            chk($sformatf("R4 v%0d addressed held", v), {7'd0, addressed}, {7'd0, hit});
            bus_stop();
            chk($sformatf("R8 v%0d busy after stop", v), {7'd0, bus_busy}, 8'd0);
            chk($sformatf("R8 v%0d addressed after stop", v), {7'd0, addressed}, 8'd0);
            chk($sformatf("R8 v%0d dir after stop", v), {7'd0, xmit_dir}, 8'd0);
            idle(Q);
        end

        // R10: STOP in the middle of the address byte
        own_addr = 7'h50;
        bus_start();
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        bus_stop();
        chk("R10 busy after early stop", {7'd0, bus_busy}, 8'd0);
        chk("R10 addressed after early stop", {7'd0, addressed}, 8'd0);
        idle(4 * Q);
        chk("R10 no pull after early stop", {7'd0, sda_pull}, 8'd0);

        // R9: repeated START while addressed
        bus_start();
        send_byte(8'hA1);
        ack_clock(1'b1, "R9 first");
        chk("R9 addressed before restart", {7'd0, addressed}, 8'd1);
        chk("R9 dir before restart", {7'd0, xmit_dir}, 8'd1);
        bus_start();
        chk("R9 addressed cleared by restart", {7'd0, addressed}, 8'd0);
        chk("R9 dir cleared by restart", {7'd0, xmit_dir}, 8'd0);
        chk("R9 busy kept by restart", {7'd0, bus_busy}, 8'd1);
        send_byte(8'h34);
        chk("R9 R3 new byte", rx_byte, 8'h34);
        ack_clock(1'b0, "R9 second");
        chk("R9 R7 no match on new byte", {7'd0, addressed}, 8'd0);
        bus_start();
        send_byte(8'hA0);
        ack_clock(1'b1, "R9 third");
        chk("R9 R4 match after restart", {7'd0, addressed}, 8'd1);
        chk("R9 R5 write dir", {7'd0, xmit_dir}, 8'd0);
        bus_stop();
        chk("R8 final stop", {7'd0, bus_busy}, 8'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule